// File: doc/BRIEF.md
# Cascadable Dual Byte Event Counter

The block holds two byte-wide event counters, a low one and a high one, each driven by a one-cycle strobe that is already synchronized to the clock. When the cascade input is low, the two counters run on their own strobes and wrap on their own. When the cascade input is high, they act as one 16-bit accumulator. Only the low strobe advances the pair, and a wrap of the low byte carries into the high byte in the same clock.

Software reaches both counters through a small byte-addressed bus. Offset 0 is the high counter, offset 1 the low counter and offset 2 a status byte. A word access at offset 0 covers both counters in a single clock, so the two bytes are captured or loaded together. Two separate byte accesses can return a pair that never existed at one instant, because counting goes on between them. In cascaded mode a wrap of the high byte sets a sticky overflow flag. That flag, gated by an enable input, drives an interrupt request.

Top module: `pulse_pair_accum`

## Requirements
- R1: A synchronous reset sets both counters to 0x00, clears the overflow flag and sets the read data to zero.
- R2: With cascade low, the low counter increments on each pulse_lo strobe and the high counter on each pulse_hi strobe. Each wraps from 0xFF to 0x00 independently, and the overflow flag is never set.
- R3: With cascade high, pulse_hi has no effect. pulse_lo increments the low counter, and a low wrap from 0xFF to 0x00 increments the high counter in the same clock.
- R4: With cascade high, a high-byte wrap from 0xFF to 0x00 sets the overflow flag (status bit 0). The flag stays set until it is cleared.
- R5: Writing a byte with bit 0 set to offset 2 clears the flag. Writing 0 to bit 0 leaves the flag unchanged. If a set and a clear occur in the same clock, the flag ends up set.
- R6: irq is high exactly when the overflow flag is set and irq_en is high.
- R7: A byte write (bus_word low) to offset 0 or 1 loads bus_wdata[7:0] into that counter. A write has priority over a count in the same clock, and an overwritten low byte produces no carry.
- R8: A word write (bus_word high) at offset 0 loads bus_wdata[15:8] into the high counter and bus_wdata[7:0] into the low counter in the same clock.
- R9: A read presents its data on bus_rdata one clock after bus_rd, with the values from before that edge. A byte read returns the byte in bits 7:0 with zeros above. A word read at offset 0 returns {high, low}. Offset 2 returns the flag in bit 0.
- R10: A word read returns the pair in one clock. Separate byte reads taken while the pair counts across a low-byte wrap return the high and low bytes from different instants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cascade_en | input | 1 | Joins the two counters into one 16-bit accumulator |
| irq_en | input | 1 | Interrupt enable for the overflow flag |
| pulse_hi | input | 1 | One-cycle count strobe for the high counter |
| pulse_lo | input | 1 | One-cycle count strobe for the low counter |
| bus_addr | input | 2 | Byte offset: 0 high, 1 low, 2 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | Word access; valid at offset 0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches the following on every cycle: write priority for byte and word loads, the carry into the high byte, the setting of the flag on a high wrap, the high counter holding still in split mode, and the flag never rising while the cascade input is low. Some behaviour shows only through the bench's scenarios, because it spans several accesses or depends on read timing. This covers the one-cycle read latency, the values returned by word versus split reads across a carry, sticky flag behaviour over many cycles, and the set-beats-clear collision. A reference model in the bench tracks both bytes and the flag against long randomized traffic.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam logic [1:0] ADDR_HI   = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/pacc_byte_ctr.sv
module pacc_byte_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         carry
);
  // a load overrides the count, so it also suppresses the carry
  assign carry = inc && !load && (&q);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= q + 1'b1;
  end
endmodule

// File: rtl/pacc_ovf_flag.sv
module pacc_ovf_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;   // a new event outranks a clear
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag && irq_en;
endmodule

// File: rtl/pulse_pair_accum.sv
module pulse_pair_accum
  import pacc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cascade_en,
  input  logic           irq_en,
  input  logic           pulse_hi,
  input  logic           pulse_lo,
  input  logic [1:0]     bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic           bus_word,
  input  logic [2*W-1:0] bus_wdata,
  output logic [2*W-1:0] bus_rdata,
  output logic           irq
);
  localparam int DW = 2 * W;

  logic           word_acc;
  logic           wr_hi, wr_lo, wr_stat;
  logic [1:0]     ld, inc, cy;
  logic [W-1:0]   ldv [2];
  logic [W-1:0]   cnt [2];
  logic [W-1:0]   cnt_lo_q, cnt_hi_q;
  logic           ovf_q;

  assign word_acc = bus_word && (bus_addr == ADDR_HI);
  assign wr_hi    = bus_wr && (bus_addr == ADDR_HI);
  assign wr_lo    = bus_wr && ((bus_addr == ADDR_LO) || word_acc);
  assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);

  // index 0 = low byte, index 1 = high byte
  assign ld     = {wr_hi, wr_lo};
  assign ldv[0] = bus_wdata[W-1:0];
  assign ldv[1] = word_acc ? bus_wdata[DW-1:W] : bus_wdata[W-1:0];
  assign inc[0] = pulse_lo;
  assign inc[1] = cascade_en ? cy[0] : pulse_hi;

  generate
    for (genvar i = 0; i < 2; i++) begin : g_ctr
      pacc_byte_ctr #(.W(W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ld[i]),
        .load_val (ldv[i]),
        .inc      (inc[i]),
        .q        (cnt[i]),
        .carry    (cy[i])
      );
    end
  endgenerate

  assign cnt_lo_q = cnt[0];
  assign cnt_hi_q = cnt[1];

  pacc_ovf_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set    (cascade_en && cy[1]),
    .clr    (wr_stat && bus_wdata[0]),
    .irq_en (irq_en),
    .flag   (ovf_q),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        ADDR_HI:   bus_rdata <= bus_word ? {cnt_hi_q, cnt_lo_q} : {{W{1'b0}}, cnt_hi_q};
        ADDR_LO:   bus_rdata <= {{W{1'b0}}, cnt_lo_q};
        ADDR_STAT: bus_rdata <= {{(DW-1){1'b0}}, ovf_q};
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           cascade_en,
  input logic           pulse_hi,
  input logic           pulse_lo,
  input logic [1:0]     bus_addr,
  input logic           bus_wr,
  input logic           bus_word,
  input logic [2*W-1:0] bus_wdata,
  input logic [W-1:0]   cnt_hi_q,
  input logic [W-1:0]   cnt_lo_q,
  input logic           ovf_q
);
  // R7: a byte write to the low counter wins over any count
  assert_lo_write_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_word && bus_addr == 2'd1) |=> cnt_lo_q == $past(bus_wdata[W-1:0]));

  // R8: a word write loads both bytes in one clock
  assert_word_load_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_word && bus_addr == 2'd0) |=> {cnt_hi_q, cnt_lo_q} == $past(bus_wdata));

  // R3: a low wrap in cascade mode carries into the high byte
  assert_cascade_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (cascade_en && pulse_lo && (&cnt_lo_q) && !bus_wr) |=> cnt_hi_q == $past(cnt_hi_q) + 1'b1);

  // R4: a high wrap in cascade mode sets the flag
  assert_flag_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (cascade_en && pulse_lo && (&cnt_lo_q) && (&cnt_hi_q) && !bus_wr) |=> ovf_q);

  // R2: split mode never raises the flag
  assert_no_flag_split_R2: assert property (@(posedge clk) disable iff (rst)
    (!cascade_en && !ovf_q) |=> !ovf_q);

  // R2: split mode high counter holds without its own strobe or a write
  assert_hi_hold_split_R2: assert property (@(posedge clk) disable iff (rst)
    (!cascade_en && !pulse_hi && !bus_wr) |=> $stable(cnt_hi_q));
endmodule

bind pulse_pair_accum pacc_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cascade_en (cascade_en),
  .pulse_hi   (pulse_hi),
  .pulse_lo   (pulse_lo),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_word   (bus_word),
  .bus_wdata  (bus_wdata),
  .cnt_hi_q   (cnt_hi_q),
  .cnt_lo_q   (cnt_lo_q),
  .ovf_q      (ovf_q)
);

// File: tb/pulse_pair_accum_tb.sv
module pulse_pair_accum_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int DW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cascade_en = 1'b0, irq_en = 1'b0, pulse_hi = 1'b0, pulse_lo = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference model
  logic [W-1:0]  m_hi = '0, m_lo = '0;
  logic          m_ovf = 1'b0;
  logic          rd_pend = 1'b0;
  logic [DW-1:0] rd_exp = '0;
  string         rd_tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_pair_accum #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .cascade_en(cascade_en), .irq_en(irq_en),
    .pulse_hi(pulse_hi), .pulse_lo(pulse_lo), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] read_val(input logic [1:0] a, input logic w);
    case (a)
      2'd0:    return w ? {m_hi, m_lo} : {{W{1'b0}}, m_hi};
      2'd1:    return {{W{1'b0}}, m_lo};
      2'd2:    return {{(DW-1){1'b0}}, m_ovf};
      default: return '0;
    endcase
  endfunction

  // one clock: checks the previous cycle's results, then drives and models this one
  task automatic cyc(input logic cas, input logic ie, input logic ph, input logic pl,
                     input logic we, input logic re, input logic ww,
                     input logic [1:0] a, input logic [DW-1:0] wd, input string tag);
    logic wlo, whi, clr, cy_lo, set;
    @(negedge clk);
    if (rd_pend) check(rd_tag, bus_rdata, rd_exp);
    check("R6 irq", {{(DW-1){1'b0}}, irq}, {{(DW-1){1'b0}}, m_ovf & irq_en});
    cascade_en = cas; irq_en = ie; pulse_hi = ph; pulse_lo = pl;
    bus_wr = we; bus_rd = re; bus_word = ww; bus_addr = a; bus_wdata = wd;
    rd_pend = re; rd_tag = tag;
    rd_exp  = read_val(a, ww);
    whi   = we && a == 2'd0;
    wlo   = we && (a == 2'd1 || (a == 2'd0 && ww));
    clr   = we && a == 2'd2 && wd[0];
    cy_lo = cas && pl && m_lo == '1 && !wlo;
    set   = cy_lo && m_hi == '1 && !whi;
    if (set)      m_ovf = 1'b1;
    else if (clr) m_ovf = 1'b0;
    if (whi)      m_hi = (a == 2'd0 && ww) ? wd[DW-1:W] : wd[W-1:0];
    else if (cas) m_hi = m_hi + W'(cy_lo);
    else          m_hi = m_hi + W'(ph);
    if (wlo)      m_lo = wd[W-1:0];
    else          m_lo = m_lo + W'(pl);
  endtask

  task automatic idle(input logic cas);
    cyc(cas, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R9 idle");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 rdata", bus_rdata, '0);
    cyc(1'b0, 1'b1, 0, 0, 0, 1, 1, 2'd0, '0, "R1 word");
    cyc(1'b0, 1'b1, 0, 0, 0, 1, 0, 2'd2, '0, "R1 status");
    // R2: split mode, low wraps alone
    cyc(1'b0, 1'b1, 0, 0, 1, 0, 1, 2'd0, 16'h05FF, "R8 load");
    cyc(1'b0, 1'b1, 0, 1, 0, 1, 1, 2'd0, '0, "R8 word read");
    cyc(1'b0, 1'b1, 0, 0, 0, 1, 1, 2'd0, '0, "R2 low wrap alone");
    cyc(1'b0, 1'b1, 1, 0, 0, 1, 0, 2'd2, '0, "R2 no flag");
    cyc(1'b0, 1'b1, 0, 0, 0, 1, 0, 2'd0, '0, "R2 high own strobe");
    // R3: cascade carry, pulse_hi ignored
    cyc(1'b1, 1'b1, 0, 0, 1, 0, 1, 2'd0, 16'h12FF, "R8 load");
    cyc(1'b1, 1'b1, 1, 1, 0, 0, 0, 2'd0, '0, "R3 carry");
    cyc(1'b1, 1'b1, 1, 0, 0, 1, 1, 2'd0, '0, "R3 carry result");
    cyc(1'b1, 1'b1, 0, 0, 0, 1, 1, 2'd0, '0, "R3 pulse_hi ignored");
    // R4: full wrap sets flag, R6 irq, sticky
    cyc(1'b1, 1'b1, 0, 0, 1, 0, 1, 2'd0, 16'hFFFF, "R8 load");
    cyc(1'b1, 1'b1, 0, 1, 0, 0, 0, 2'd0, '0, "R4 wrap");
    cyc(1'b1, 1'b1, 0, 0, 0, 1, 0, 2'd2, '0, "R4 flag set");
    cyc(1'b1, 1'b0, 0, 0, 0, 1, 0, 2'd2, '0, "R4 flag sticky");
    // R5: writing 0 keeps flag, writing 1 clears
    cyc(1'b1, 1'b1, 0, 0, 1, 0, 0, 2'd2, 16'h0000, "R5 write0");
    cyc(1'b1, 1'b1, 0, 0, 0, 1, 0, 2'd2, '0, "R5 flag kept");
    cyc(1'b1, 1'b1, 0, 0, 1, 0, 0, 2'd2, 16'h0001, "R5 clear");
    cyc(1'b1, 1'b1, 0, 0, 0, 1, 0, 2'd2, '0, "R5 flag cleared");
    // R5: set and clear together -> set
    cyc(1'b1, 1'b1, 0, 0, 1, 0, 1, 2'd0, 16'hFFFF, "R8 load");
    cyc(1'b1, 1'b1, 0, 1, 1, 0, 0, 2'd2, 16'h0001, "R5 collide");
    cyc(1'b1, 1'b1, 0, 0, 0, 1, 0, 2'd2, '0, "R5 set wins");
    // R7: write beats count, no carry from overwritten low
    cyc(1'b1, 1'b1, 0, 0, 1, 0, 1, 2'd0, 16'h20FF, "R8 load");
    cyc(1'b1, 1'b1, 0, 1, 1, 0, 0, 2'd1, 16'h0042, "R7 write vs count");
    cyc(1'b1, 1'b1, 0, 0, 0, 1, 1, 2'd0, '0, "R7 write wins no carry");
    // R10: split reads across a carry vs word read
    cyc(1'b1, 1'b1, 0, 0, 1, 0, 1, 2'd0, 16'h30FF, "R8 load");
    cyc(1'b1, 1'b1, 0, 1, 0, 1, 0, 2'd1, '0, "R10 split low first");
    cyc(1'b1, 1'b1, 0, 0, 0, 1, 0, 2'd0, '0, "R10 split high after carry");
    cyc(1'b1, 1'b1, 0, 0, 0, 1, 1, 2'd0, '0, "R10 word coherent");
    // randomized traffic
    for (int i = 0; i < 4000; i++) begin
      logic [DW-1:0] wd;
      logic [1:0]    a;
      a  = 2'($urandom % 4);
      wd = ($urandom % 3 == 0) ? DW'(16'hFFFF - ($urandom % 3)) : DW'($urandom);
      cyc(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 2) == 1, ($urandom % 4) != 0,
          ($urandom % 10) == 0, ($urandom % 3) == 0, ($urandom % 2) == 1, a, wd, "R9 random");
    end
    idle(1'b1);
    idle(1'b1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule